// File: doc/BRIEF.md
# Microcontroller Interrupt Controller

This block collects interrupt requests for a small 8-bit controller core and decides when the instruction sequencer must divert to the interrupt vector. Three core sources feed it: a synchronized external pin edge, a port-change event and a timer overflow. Their sticky flags and enables sit in one control register, together with a peripheral enable and a master enable. Two further flag/enable register pairs hold peripheral sources. The peripheral enable gates all of them.

The block raises `irq` while the master enable is set and at least one enabled source has its flag set. The sequencer answers with `ack`. One cycle later the block pulses `vec_taken`, pushes the captured return address through a one-word stack interface and presents the vector address 0x0004 to load into the PC. In the same step it clears the master enable. A return-from-interrupt strobe sets the master enable again. Software must clear flags itself. Hardware never clears them.

Top module: `mcu_intc`

## Requirements
- R1: After reset every register reads as zero: control, both peripheral flag registers and both peripheral enable registers. `irq`, `vec_taken` and `stk_push` are low.
- R2: A source event sets its flag whatever the state of its own enable, the peripheral enable and the master enable.
- R3: `irq` is high exactly when the master enable (control bit 7) is set and some core source has both its flag and its enable set, or the peripheral condition of R4 holds.
- R4: A peripheral source can raise `irq` only while the peripheral enable (control bit 6) is set, along with its own flag and enable bit and the master enable.
- R5: When `ack` is high while `irq` is high, on the next cycle the master enable reads 0, `vec_taken` and `stk_push` pulse for one cycle, `stk_data` holds the `ret_pc` sampled with `ack`, and `pc_vec` is 0x0004.
- R6: `ack` while `irq` is low has no effect: no `vec_taken` pulse and no change to the master enable.
- R7: Taking an interrupt does not clear any flag, so after return the same source requests again unless software has cleared it.
- R8: A `reti` strobe sets the master enable on the next cycle, unless an acknowledge is accepted in that same cycle.
- R9: A software write that clears the master enable in the same cycle as an accepted `ack` does not cancel the acknowledge. The later `reti` sets the master enable again.
- R10: The external pin passes through two synchronizing flops and an edge detector. `pin_rise_sel`=1 selects rising edges and 0 selects falling edges. The pin flag is readable after the third rising clock edge that follows the pin change. Edges of the other polarity never set it.
- R11: When a source event and a software write clearing that flag land in the same cycle, the flag ends up set.
- R12: Register selects: 0 control, 1 peripheral flags A, 2 peripheral flags B, 3 peripheral enables A, 4 peripheral enables B; other selects read 0. Control layout: bit 7 master enable, 6 peripheral enable, 5 timer enable, 4 pin enable, 3 port-change enable, 2 timer flag, 1 pin flag, 0 port-change flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 8 | Write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 8 | Read data (combinational) |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| pin_rise_sel | input | 1 | 1 rising edge, 0 falling edge |
| port_chg | input | 1 | Port-change event pulse |
| tmr_ovf | input | 1 | Timer overflow event pulse |
| per_evt | input | 16 | Peripheral event pulses, bank A in [7:0], bank B in [15:8] |
| ack | input | 1 | Sequencer acknowledge |
| reti | input | 1 | Return-from-interrupt strobe |
| ret_pc | input | 13 | Return address to push on acknowledge |
| irq | output | 1 | Interrupt request |
| vec_taken | output | 1 | One-cycle pulse: load PC with `pc_vec` |
| pc_vec | output | 13 | Interrupt vector address (0x0004) |
| stk_push | output | 1 | Stack push strobe |
| stk_data | output | 13 | Address to push |

## Verification
The bench targets the race between a software master-enable clear and an acknowledge. A design that let the write win would drop the pulse and leave the return unable to re-enable. It checks that flags survive the acknowledge, since a design that cleared them would lose the re-request after return. It drives a flag clear and a new event in the same cycle, where a wrong priority silently loses an event. It counts the pin latency edge by edge and uses both polarities. An extra or missing synchronizer stage, or a detector that ignores the select, shows up as a flag one cycle early or late or set on the wrong edge.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned SEL_W     = 3;
  localparam int unsigned CORE_N    = 3;
  localparam int unsigned BIT_GIE   = 7;
  localparam int unsigned BIT_PEIE  = 6;
  localparam int unsigned CORE_ENL  = 3;
  localparam int unsigned CORE_FLGL = 0;
  // core source index inside the flag/enable fields
  localparam int unsigned SRC_PORT  = 0;
  localparam int unsigned SRC_PIN   = 1;
  localparam int unsigned SRC_TMR   = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL  = 3'd0,
    SEL_PFLGA = 3'd1,
    SEL_PFLGB = 3'd2,
    SEL_PENA  = 3'd3,
    SEL_PENB  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/intc_edge_sync.sv
module intc_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  input  logic rise_sel,
  output logic edge_pulse
);
  logic s1_q, s2_q, prev_q;
  logic s1_d, s2_d, prev_d;

  always_comb begin
    s1_d   = pin_async;
    s2_d   = s1_q;
    prev_d = s2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= s1_d;
      s2_q   <= s2_d;
      prev_q <= prev_d;
    end
  end

  always_comb begin
    if (rise_sel) edge_pulse = s2_q & ~prev_q;
    else          edge_pulse = ~s2_q & prev_q;
  end

  // an edge of one polarity needs the opposite one before it can repeat
  assert_no_back_to_back_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_pulse && $stable(rise_sel)) |=> !edge_pulse);
endmodule

// File: rtl/intc_src_bank.sv
module intc_src_bank #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flag_we,
  input  logic         en_we,
  input  logic [N-1:0] flag_wdata,
  input  logic [N-1:0] en_wdata,
  input  logic [N-1:0] evt,
  output logic [N-1:0] flags,
  output logic [N-1:0] enables,
  output logic         pend
);
  logic [N-1:0] flag_q, flag_d;
  logic [N-1:0] en_q, en_d;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb begin
      // an event always wins over a same-cycle software clear
      flag_d[i] = evt[i] | (flag_we ? flag_wdata[i] : flag_q[i]);
      en_d[i]   = en_we ? en_wdata[i] : en_q[i];
    end

    assert_evt_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> flags[i]);
    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !flag_we) |=> flags[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      flag_q <= flag_d;
      en_q   <= en_d;
    end
  end

  assign flags   = flag_q;
  assign enables = en_q;
  assign pend    = |(flag_q & en_q);
endmodule

// File: rtl/intc_vector_ctl.sv
module intc_vector_ctl #(
  parameter int unsigned PC_W     = 13,
  parameter int unsigned VEC_ADDR = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctrl_we,
  input  logic            wr_gie,
  input  logic            wr_peie,
  input  logic            ack,
  input  logic            reti,
  input  logic            core_pend,
  input  logic            peri_pend,
  input  logic [PC_W-1:0] ret_pc,
  output logic            gie,
  output logic            peie,
  output logic            irq,
  output logic            vec_taken,
  output logic [PC_W-1:0] pc_vec,
  output logic            stk_push,
  output logic [PC_W-1:0] stk_data
);
  logic            gie_q, gie_d;
  logic            peie_q, peie_d;
  logic            taken_q, taken_d;
  logic [PC_W-1:0] addr_q, addr_d;
  logic            take;

  always_comb begin
    irq  = gie_q & (core_pend | (peie_q & peri_pend));
    take = ack & irq;
    // priority: acknowledge, then return, then software write
    if (take)         gie_d = 1'b0;
    else if (reti)    gie_d = 1'b1;
    else if (ctrl_we) gie_d = wr_gie;
    else              gie_d = gie_q;
    peie_d  = ctrl_we ? wr_peie : peie_q;
    taken_d = take;
    addr_d  = take ? ret_pc : addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q   <= 1'b0;
      peie_q  <= 1'b0;
      taken_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      gie_q   <= gie_d;
      peie_q  <= peie_d;
      taken_q <= taken_d;
      addr_q  <= addr_d;
    end
  end

  assign gie       = gie_q;
  assign peie      = peie_q;
  assign vec_taken = taken_q;
  assign stk_push  = taken_q;
  assign stk_data  = addr_q;
  assign pc_vec    = PC_W'(VEC_ADDR);

  assert_ack_clears_gie_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq) |=> (!gie && vec_taken));
  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_taken |=> !vec_taken);
  assert_push_with_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_taken |-> stk_push);
  assert_irq_needs_gie_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> gie);
  assert_idle_ack_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq) |=> !vec_taken);
  assert_reti_sets_gie_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !(ack && irq)) |=> gie);
endmodule

// File: rtl/mcu_intc.sv
module mcu_intc
  import intc_pkg::*;
#(
  parameter int unsigned PER_N    = 8,
  parameter int unsigned PC_W     = 13,
  parameter int unsigned VEC_ADDR = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SEL_W-1:0]     wr_sel,
  input  logic [REG_W-1:0]     wr_data,
  input  logic [SEL_W-1:0]     rd_sel,
  output logic [REG_W-1:0]     rd_data,
  input  logic                 ext_pin,
  input  logic                 pin_rise_sel,
  input  logic                 port_chg,
  input  logic                 tmr_ovf,
  input  logic [2*PER_N-1:0]   per_evt,
  input  logic                 ack,
  input  logic                 reti,
  input  logic [PC_W-1:0]      ret_pc,
  output logic                 irq,
  output logic                 vec_taken,
  output logic [PC_W-1:0]      pc_vec,
  output logic                 stk_push,
  output logic [PC_W-1:0]      stk_data
);
  localparam int unsigned BANKS = 2;

  // reset: asserted asynchronously, released on the clock
  logic rst_m_q, rst_s_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  logic ctrl_we;
  logic pin_pulse;
  logic [CORE_N-1:0] core_evt, core_flags, core_en;
  logic core_pend;
  logic gie, peie;
  logic [BANKS-1:0] bank_pend;
  logic [PER_N-1:0] bank_flags [BANKS];
  logic [PER_N-1:0] bank_en    [BANKS];

  assign ctrl_we = wr_en && (wr_sel == SEL_CTRL);

  intc_edge_sync u_pin (
    .clk        (clk),
    .rst_n      (rst_s_q),
    .pin_async  (ext_pin),
    .rise_sel   (pin_rise_sel),
    .edge_pulse (pin_pulse)
  );

  always_comb begin
    core_evt           = '0;
    core_evt[SRC_PORT] = port_chg;
    core_evt[SRC_PIN]  = pin_pulse;
    core_evt[SRC_TMR]  = tmr_ovf;
  end

  intc_src_bank #(.N(CORE_N)) u_core (
    .clk        (clk),
    .rst_n      (rst_s_q),
    .flag_we    (ctrl_we),
    .en_we      (ctrl_we),
    .flag_wdata (wr_data[CORE_FLGL +: CORE_N]),
    .en_wdata   (wr_data[CORE_ENL +: CORE_N]),
    .evt        (core_evt),
    .flags      (core_flags),
    .enables    (core_en),
    .pend       (core_pend)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic flag_we_b, en_we_b;
    assign flag_we_b = wr_en && (wr_sel == SEL_W'(SEL_PFLGA) + SEL_W'(b));
    assign en_we_b   = wr_en && (wr_sel == SEL_W'(SEL_PENA) + SEL_W'(b));
    intc_src_bank #(.N(PER_N)) u_per (
      .clk        (clk),
      .rst_n      (rst_s_q),
      .flag_we    (flag_we_b),
      .en_we      (en_we_b),
      .flag_wdata (wr_data[PER_N-1:0]),
      .en_wdata   (wr_data[PER_N-1:0]),
      .evt        (per_evt[b*PER_N +: PER_N]),
      .flags      (bank_flags[b]),
      .enables    (bank_en[b]),
      .pend       (bank_pend[b])
    );
  end

  intc_vector_ctl #(.PC_W(PC_W), .VEC_ADDR(VEC_ADDR)) u_vec (
    .clk       (clk),
    .rst_n     (rst_s_q),
    .ctrl_we   (ctrl_we),
    .wr_gie    (wr_data[BIT_GIE]),
    .wr_peie   (wr_data[BIT_PEIE]),
    .ack       (ack),
    .reti      (reti),
    .core_pend (core_pend),
    .peri_pend (|bank_pend),
    .ret_pc    (ret_pc),
    .gie       (gie),
    .peie      (peie),
    .irq       (irq),
    .vec_taken (vec_taken),
    .pc_vec    (pc_vec),
    .stk_push  (stk_push),
    .stk_data  (stk_data)
  );

  always_comb begin
    rd_data = '0;
    unique case (rd_sel)
      SEL_CTRL: begin
        rd_data[BIT_GIE]               = gie;
        rd_data[BIT_PEIE]              = peie;
        rd_data[CORE_ENL +: CORE_N]    = core_en;
        rd_data[CORE_FLGL +: CORE_N]   = core_flags;
      end
      SEL_PFLGA: rd_data[PER_N-1:0] = bank_flags[0];
      SEL_PFLGB: rd_data[PER_N-1:0] = bank_flags[1];
      SEL_PENA:  rd_data[PER_N-1:0] = bank_en[0];
      SEL_PENB:  rd_data[PER_N-1:0] = bank_en[1];
      default:   rd_data = '0;
    endcase
  end

  assert_periph_gated_R4: assert property (@(posedge clk) disable iff (!rst_s_q)
    (irq && !core_pend) |-> peie);
endmodule

// File: tb/mcu_intc_tb.sv
module mcu_intc_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_sel;
  logic [7:0]  wr_data;
  logic [2:0]  rd_sel;
  logic [7:0]  rd_data;
  logic        ext_pin, pin_rise_sel, port_chg, tmr_ovf;
  logic [15:0] per_evt;
  logic        ack, reti;
  logic [12:0] ret_pc;
  logic        irq, vec_taken, stk_push;
  logic [12:0] pc_vec, stk_data;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  mcu_intc u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .ext_pin(ext_pin), .pin_rise_sel(pin_rise_sel),
    .port_chg(port_chg), .tmr_ovf(tmr_ovf), .per_evt(per_evt), .ack(ack), .reti(reti),
    .ret_pc(ret_pc), .irq(irq), .vec_taken(vec_taken), .pc_vec(pc_vec),
    .stk_push(stk_push), .stk_data(stk_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] rd(input logic [2:0] s);
    rd_sel = s;
    return 8'h00;
  endfunction

  task automatic rdchk(input string req, input logic [2:0] s, input logic [7:0] exp);
    logic [7:0] dummy;
    dummy = rd(s);
    #1;
    chk(req, {24'd0, rd_data}, {24'd0, exp});
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    cyc(1);
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    rdchk("R1 ctrl", 3'd0, 8'h00);
    rdchk("R1 pflgA", 3'd1, 8'h00);
    rdchk("R1 pflgB", 3'd2, 8'h00);
    rdchk("R1 penA", 3'd3, 8'h00);
    rdchk("R1 penB", 3'd4, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 vec_taken", vec_taken, 0);
    chk("R1 stk_push", stk_push, 0);
  endtask

  task automatic t_core_mask;
    tmr_ovf = 1'b1; cyc(1); tmr_ovf = 1'b0;
    rdchk("R2 timer flag with all masks off", 3'd0, 8'h04);
    chk("R3 no irq while masked", irq, 0);
    wr(3'd0, 8'h24);
    chk("R3 no irq without master enable", irq, 0);
    wr(3'd0, 8'hA4);
    chk("R3 irq when enabled", irq, 1);
    wr(3'd0, 8'hA0);
    chk("R3 irq drops with flag", irq, 0);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_periph;
    per_evt = 16'h0108; cyc(1); per_evt = 16'h0000;
    rdchk("R2 periph flags A", 3'd1, 8'h08);
    rdchk("R2 periph flags B", 3'd2, 8'h01);
    wr(3'd3, 8'h08);
    rdchk("R12 enable A readback", 3'd3, 8'h08);
    wr(3'd0, 8'h80);
    chk("R4 no irq without peripheral enable", irq, 0);
    wr(3'd0, 8'hC0);
    chk("R4 irq with peripheral enable", irq, 1);
    wr(3'd3, 8'h00);
    wr(3'd4, 8'h01);
    chk("R4 bank B source", irq, 1);
    rdchk("R12 unused select", 3'd6, 8'h00);
    wr(3'd0, 8'h00); wr(3'd4, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'h00);
  endtask

  task automatic t_ack;
    tmr_ovf = 1'b1; cyc(1); tmr_ovf = 1'b0;
    wr(3'd0, 8'hA4);
    ret_pc = 13'h0123; ack = 1'b1; cyc(1); ack = 1'b0;
    chk("R5 vec_taken", vec_taken, 1);
    chk("R5 stk_push", stk_push, 1);
    chk("R5 stk_data", stk_data, 13'h0123);
    chk("R5 pc_vec", pc_vec, 13'h0004);
    chk("R5 irq off", irq, 0);
    rdchk("R7 flag kept, master cleared", 3'd0, 8'h24);
    cyc(1);
    chk("R5 single pulse", vec_taken, 0);
    reti = 1'b1; cyc(1); reti = 1'b0;
    rdchk("R8 reti sets master", 3'd0, 8'hA4);
    chk("R7 re-request after return", irq, 1);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_idle_ack;
    wr(3'd0, 8'h80);
    ack = 1'b1; cyc(1); ack = 1'b0;
    chk("R6 no pulse", vec_taken, 0);
    rdchk("R6 master unchanged", 3'd0, 8'h80);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_race;
    tmr_ovf = 1'b1; cyc(1); tmr_ovf = 1'b0;
    wr(3'd0, 8'hA4);
    ack = 1'b1; wr_en = 1'b1; wr_sel = 3'd0; wr_data = 8'h24;
    cyc(1);
    ack = 1'b0; wr_en = 1'b0;
    chk("R9 ack proceeds", vec_taken, 1);
    rdchk("R9 master clear", 3'd0, 8'h24);
    reti = 1'b1; cyc(1); reti = 1'b0;
    rdchk("R9 reti re-enables", 3'd0, 8'hA4);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_pin;
    pin_rise_sel = 1'b1;
    ext_pin = 1'b1;
    cyc(2);
    rdchk("R10 not yet after two edges", 3'd0, 8'h00);
    cyc(1);
    rdchk("R10 flag after third edge", 3'd0, 8'h02);
    wr(3'd0, 8'h00);
    ext_pin = 1'b0; cyc(4);
    rdchk("R10 falling ignored in rise mode", 3'd0, 8'h00);
    pin_rise_sel = 1'b0;
    ext_pin = 1'b1; cyc(4);
    rdchk("R10 rising ignored in fall mode", 3'd0, 8'h00);
    ext_pin = 1'b0; cyc(2);
    rdchk("R10 fall not yet", 3'd0, 8'h00);
    cyc(1);
    rdchk("R10 fall flag", 3'd0, 8'h02);
    wr(3'd0, 8'h00);
    pin_rise_sel = 1'b1;
  endtask

  task automatic t_clear_race;
    port_chg = 1'b1; cyc(1); port_chg = 1'b0;
    rdchk("R2 port flag", 3'd0, 8'h01);
    port_chg = 1'b1; wr_en = 1'b1; wr_sel = 3'd0; wr_data = 8'h00;
    cyc(1);
    port_chg = 1'b0; wr_en = 1'b0;
    rdchk("R11 event beats clear", 3'd0, 8'h01);
    wr(3'd0, 8'h00);
    rdchk("R11 plain clear", 3'd0, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 0; wr_sel = 0; wr_data = 0; rd_sel = 0;
    ext_pin = 0; pin_rise_sel = 1; port_chg = 0; tmr_ovf = 0; per_evt = 0;
    ack = 0; reti = 0; ret_pc = 0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    t_reset();
    t_core_mask();
    t_periph();
    t_ack();
    t_idle_ack();
    t_race();
    t_pin();
    t_clear_race();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule